// File: doc/BRIEF.md
# Dual-Processor Interrupt and Control Bank

This block gives each of two processors, a master and a slave, its own bank of small control registers. Both banks share one frame-event generator. A bank holds a 3-bit priority level for each of five interrupt sources:

- the inter-processor interrupt
- an external request
- a raster-position event
- a serial request
- the vertical-blank event

Each bank drives a 3-bit priority request to its processor. A processor clears a pending source by touching that source's acknowledge slot, with either a read or a write. The two banks are cross-wired, so a write to the trigger slot of one bank raises the inter-processor interrupt in the other. The other bank presents that interrupt at its own configured level.

Registers are chosen by a 5-bit slot index, which is byte-address bits 17:13 of a window based at 0x1c0000. Each write keeps only data bits 2:0. The master bank also controls the reset lines of the sub-processors:

- the sound processor
- the slave processor
- the I/O processor

All of them come out of system reset held in reset. The frame generator divides time into LINES lines of LINE_CYCLES clocks each. It raises vertical blank at the start of line 0 and a position event at the start of line POS_LINE.

Top module: `irq_ctrl_pair`

## Requirements
- R1: After reset every slot reads 0, both priority outputs are 0, and snd_rst, slv_rst and io_rst are all 1 (held in reset).
- R2: A write stores wdata[2:0] in the slot given by the index. A later read of that slot returns the stored value zero-extended to 16 bits on rdata in the cycle after the read strobe.
- R3: Slots 3, 4, 5, 6 and 7 hold the levels of the inter-processor, external, position, serial and vertical-blank sources. The priority output is the highest level among pending sources, and a source whose level is 0 never raises it.
- R4: Any read or write at slot 11, 12, 13, 14 or 15 clears the pending inter-processor, external, position, serial or vertical-blank source of that bank. If a new event arrives in the same cycle, the source stays pending.
- R5: A write to slot 10 makes the inter-processor source pending in the other bank, which requests at the level in its own slot 3. The writer's own request does not change.
- R6: A read of slot 16 returns 0xFFFF (bit 0 set = storage ready), whatever was written there.
- R7: A master write to slot 17 releases the sound processor from reset when wdata[0] is 1 and holds it when 0. Slave writes to slots 17 and 18 do not change any reset output.
- R8: A master write to slot 18 releases the slave and I/O processors together when wdata[0] is 1 and holds both when 0.
- R9: A write to slot 19 pulses that bank's watchdog-kick output high for exactly one cycle, starting in the cycle after the write.
- R10: A one-cycle pulse on an external or serial request input makes that source pending in its bank.
- R11: Vertical blank makes its source pending in both banks on the first clock edge after reset and then every LINES*LINE_CYCLES clocks.
- R12: The position event occurs POS_LINE*LINE_CYCLES clocks after each vertical blank. It makes the position source pending only in a bank whose position level is nonzero at that moment; otherwise it is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_sel | input | 1 | Master bus access strobe, one cycle per access |
| m_we | input | 1 | Master access is a write |
| m_idx | input | 5 | Master slot index (byte address bits 17:13) |
| m_wdata | input | 3 | Master write data bits 2:0 |
| m_rdata | output | 16 | Master read data, valid the cycle after a read |
| m_ext_irq | input | 1 | Master external request pulse |
| m_ser_irq | input | 1 | Master serial request pulse |
| m_ipl | output | 3 | Master priority request |
| m_wdog_kick | output | 1 | Master watchdog-kick pulse |
| s_sel | input | 1 | Slave bus access strobe |
| s_we | input | 1 | Slave access is a write |
| s_idx | input | 5 | Slave slot index |
| s_wdata | input | 3 | Slave write data bits 2:0 |
| s_rdata | output | 16 | Slave read data |
| s_ext_irq | input | 1 | Slave external request pulse |
| s_ser_irq | input | 1 | Slave serial request pulse |
| s_ipl | output | 3 | Slave priority request |
| s_wdog_kick | output | 1 | Slave watchdog-kick pulse |
| snd_rst | output | 1 | Sound processor held in reset when 1 |
| slv_rst | output | 1 | Slave processor held in reset when 1 |
| io_rst | output | 1 | I/O processor held in reset when 1 |

## Verification
Pending flags, reset holds, stored slots and the read register all update on the clock edge that samples a strobe or pulse. The priority output is combinational from pending flags and levels, so it is valid in the same cycle those registers change. Read data and the watchdog pulse therefore appear one edge after the strobe. The bench drives on falling edges and samples on the next falling edge, which is exactly one rising edge after the stimulus. The frame events are checked against the bench's own count of rising edges since reset: vertical blank lands on edge 1 + k*LINES*LINE_CYCLES and the position event POS_LINE*LINE_CYCLES edges after it. The outputs are compared one edge before and on that edge.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int IDX_W = 5;
  localparam int NREG  = 1 << IDX_W;
  localparam int LVL_W = 3;
  localparam int NSRC  = 5;

  // source order: shared by level slots and acknowledge slots
  localparam int SRC_IPI = 0;
  localparam int SRC_EXT = 1;
  localparam int SRC_POS = 2;
  localparam int SRC_SER = 3;
  localparam int SRC_VBL = 4;

  localparam int SLOT_LVL_BASE = 3;
  localparam int SLOT_IPI_TRIG = 10;
  localparam int SLOT_ACK_BASE = 11;
  localparam int SLOT_EE_STAT  = 16;
  localparam int SLOT_SND_CTL  = 17;
  localparam int SLOT_SUB_CTL  = 18;
  localparam int SLOT_WDOG     = 19;

  typedef logic [NSRC-1:0][LVL_W-1:0] lvl_vec_t;

  function automatic logic [IDX_W-1:0] slot_of(input int s);
    return IDX_W'(s);
  endfunction

  // highest level among pending sources; level 0 contributes nothing
  function automatic logic [LVL_W-1:0] top_level(input logic [NSRC-1:0] pend,
                                                 input lvl_vec_t lvl);
    logic [LVL_W-1:0] best;
    best = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i] && (lvl[i] > best)) best = lvl[i];
    end
    return best;
  endfunction
endpackage

// File: rtl/frame_timer.sv
module frame_timer #(
  parameter int LINE_CYCLES = 16,
  parameter int LINES       = 256,
  parameter int POS_LINE    = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic vbl_evt,
  output logic pos_evt
);
  localparam int CYC_W  = $clog2(LINE_CYCLES + 1);
  localparam int LINE_W = $clog2(LINES + 1);
  localparam logic [CYC_W-1:0]  LAST_CYC  = CYC_W'(LINE_CYCLES - 1);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);
  localparam logic [LINE_W-1:0] POS_AT    = LINE_W'(POS_LINE);

  logic [CYC_W-1:0]  cyc;
  logic [LINE_W-1:0] line;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc  <= '0;
      line <= '0;
    end else if (cyc == LAST_CYC) begin
      cyc  <= '0;
      line <= (line == LAST_LINE) ? '0 : line + 1'b1;
    end else begin
      cyc <= cyc + 1'b1;
    end
  end

  assign vbl_evt = (cyc == '0) && (line == '0);
  assign pos_evt = (cyc == '0) && (line == POS_AT);

  // R11
  vbl_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vbl_evt |=> !vbl_evt);
endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import irq_bank_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [LVL_W-1:0]  wval,
  output logic [DATA_W-1:0] rdata,
  input  logic              ext_evt,
  input  logic              ser_evt,
  input  logic              pos_evt,
  input  logic              vbl_evt,
  input  logic              ipi_in,
  output logic              ipi_out,
  output logic [LVL_W-1:0]  ipl,
  output logic              wdog_kick
);
  logic             wr, rd;
  logic [LVL_W-1:0] regs [NREG];
  lvl_vec_t         lvl;
  logic [NSRC-1:0]  set_vec, ack_hit, pend;

  assign wr = sel && we;
  assign rd = sel && !we;

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                         regs[g] <= '0;
      else if (wr && idx == slot_of(g))   regs[g] <= wval;
    end
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign lvl[s]     = regs[SLOT_LVL_BASE + s];
    assign ack_hit[s] = sel && (idx == slot_of(SLOT_ACK_BASE + s));
    always_ff @(posedge clk) begin
      if (!rst_n)          pend[s] <= 1'b0;
      else if (set_vec[s]) pend[s] <= 1'b1;
      else if (ack_hit[s]) pend[s] <= 1'b0;
    end
    // R4
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit[s] && !set_vec[s]) |=> !pend[s]);
  end

  assign set_vec[SRC_IPI] = ipi_in;
  assign set_vec[SRC_EXT] = ext_evt;
  assign set_vec[SRC_POS] = pos_evt && (lvl[SRC_POS] != '0);
  assign set_vec[SRC_SER] = ser_evt;
  assign set_vec[SRC_VBL] = vbl_evt;

  assign ipi_out = wr && (idx == slot_of(SLOT_IPI_TRIG));
  assign ipl     = top_level(pend, lvl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata     <= '0;
      wdog_kick <= 1'b0;
    end else begin
      wdog_kick <= wr && (idx == slot_of(SLOT_WDOG));
      if (rd) begin
        if (idx == slot_of(SLOT_EE_STAT)) rdata <= '1;
        else                               rdata <= DATA_W'(regs[idx]);
      end
    end
  end

  // R2
  store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (regs[$past(idx)] == $past(wval)));
  // R3
  no_idle_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ipl != '0) |-> (pend != '0));
  // R6
  ee_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && idx == slot_of(SLOT_EE_STAT)) |=> (rdata == '1));
  // R9
  kick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == slot_of(SLOT_WDOG)) |=> wdog_kick);
endmodule

// File: rtl/subreset_ctl.sv
module subreset_ctl
  import irq_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic             wbit,
  output logic             snd_hold,
  output logic             sub_hold
);
  logic snd_wr, sub_wr;
  assign snd_wr = sel && we && (idx == slot_of(SLOT_SND_CTL));
  assign sub_wr = sel && we && (idx == slot_of(SLOT_SUB_CTL));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snd_hold <= 1'b1;
      sub_hold <= 1'b1;
    end else begin
      if (snd_wr) snd_hold <= !wbit;
      if (sub_wr) sub_hold <= !wbit;
    end
  end

  // R7
  snd_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snd_wr |=> (snd_hold == !$past(wbit)));
  // R8
  sub_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_wr |=> (sub_hold == !$past(wbit)));
endmodule

// File: rtl/irq_ctrl_pair.sv
module irq_ctrl_pair
  import irq_bank_pkg::*;
#(
  parameter int LINE_CYCLES = 16,
  parameter int LINES       = 256,
  parameter int POS_LINE    = 64,
  parameter int DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m_sel,
  input  logic              m_we,
  input  logic [IDX_W-1:0]  m_idx,
  input  logic [LVL_W-1:0]  m_wdata,
  output logic [DATA_W-1:0] m_rdata,
  input  logic              m_ext_irq,
  input  logic              m_ser_irq,
  output logic [LVL_W-1:0]  m_ipl,
  output logic              m_wdog_kick,
  input  logic              s_sel,
  input  logic              s_we,
  input  logic [IDX_W-1:0]  s_idx,
  input  logic [LVL_W-1:0]  s_wdata,
  output logic [DATA_W-1:0] s_rdata,
  input  logic              s_ext_irq,
  input  logic              s_ser_irq,
  output logic [LVL_W-1:0]  s_ipl,
  output logic              s_wdog_kick,
  output logic              snd_rst,
  output logic              slv_rst,
  output logic              io_rst
);
  logic vbl_evt, pos_evt;
  logic m_to_s_ipi, s_to_m_ipi;
  logic sub_hold;

  frame_timer #(.LINE_CYCLES(LINE_CYCLES), .LINES(LINES), .POS_LINE(POS_LINE)) u_frame (
    .clk(clk), .rst_n(rst_n), .vbl_evt(vbl_evt), .pos_evt(pos_evt));

  irq_bank #(.DATA_W(DATA_W)) u_mbank (
    .clk(clk), .rst_n(rst_n), .sel(m_sel), .we(m_we), .idx(m_idx), .wval(m_wdata),
    .rdata(m_rdata), .ext_evt(m_ext_irq), .ser_evt(m_ser_irq), .pos_evt(pos_evt),
    .vbl_evt(vbl_evt), .ipi_in(s_to_m_ipi), .ipi_out(m_to_s_ipi), .ipl(m_ipl),
    .wdog_kick(m_wdog_kick));

  irq_bank #(.DATA_W(DATA_W)) u_sbank (
    .clk(clk), .rst_n(rst_n), .sel(s_sel), .we(s_we), .idx(s_idx), .wval(s_wdata),
    .rdata(s_rdata), .ext_evt(s_ext_irq), .ser_evt(s_ser_irq), .pos_evt(pos_evt),
    .vbl_evt(vbl_evt), .ipi_in(m_to_s_ipi), .ipi_out(s_to_m_ipi), .ipl(s_ipl),
    .wdog_kick(s_wdog_kick));

  // only the master's bus reaches the sub-processor reset holds
  subreset_ctl u_reset (
    .clk(clk), .rst_n(rst_n), .sel(m_sel), .we(m_we), .idx(m_idx), .wbit(m_wdata[0]),
    .snd_hold(snd_rst), .sub_hold(sub_hold));

  assign slv_rst = sub_hold;
  assign io_rst  = sub_hold;
endmodule

// File: tb/sim_irq_ctrl_pair.sv
module sim_irq_ctrl_pair;
  localparam int LC    = 4;
  localparam int NL    = 256;
  localparam int PL    = 64;
  localparam int FRAME = LC * NL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_sel = 0, m_we = 0, s_sel = 0, s_we = 0;
  logic [4:0] m_idx = 0, s_idx = 0;
  logic [2:0] m_wdata = 0, s_wdata = 0;
  logic m_ext = 0, m_ser = 0, s_ext = 0, s_ser = 0;
  logic [15:0] m_rdata, s_rdata;
  logic [2:0] m_ipl, s_ipl;
  logic m_kick, s_kick, snd_rst, slv_rst, io_rst;

  int checks = 0;
  int errors = 0;
  int edges = 0;

  always #5 clk = ~clk;
  always @(posedge clk) if (rst_n) edges <= edges + 1;

  irq_ctrl_pair #(.LINE_CYCLES(LC), .LINES(NL), .POS_LINE(PL)) u0 (
    .clk(clk), .rst_n(rst_n),
    .m_sel(m_sel), .m_we(m_we), .m_idx(m_idx), .m_wdata(m_wdata), .m_rdata(m_rdata),
    .m_ext_irq(m_ext), .m_ser_irq(m_ser), .m_ipl(m_ipl), .m_wdog_kick(m_kick),
    .s_sel(s_sel), .s_we(s_we), .s_idx(s_idx), .s_wdata(s_wdata), .s_rdata(s_rdata),
    .s_ext_irq(s_ext), .s_ser_irq(s_ser), .s_ipl(s_ipl), .s_wdog_kick(s_kick),
    .snd_rst(snd_rst), .slv_rst(slv_rst), .io_rst(io_rst));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic bus_wr(input bit slave, input int idx, input logic [2:0] d);
    if (slave) begin s_sel = 1; s_we = 1; s_idx = 5'(idx); s_wdata = d; end
    else       begin m_sel = 1; m_we = 1; m_idx = 5'(idx); m_wdata = d; end
    @(negedge clk);
    s_sel = 0; s_we = 0; m_sel = 0; m_we = 0;
  endtask

  task automatic bus_rd(input bit slave, input int idx, output logic [15:0] q);
    if (slave) begin s_sel = 1; s_we = 0; s_idx = 5'(idx); end
    else       begin m_sel = 1; m_we = 0; m_idx = 5'(idx); end
    @(negedge clk);
    q = slave ? s_rdata : m_rdata;
    s_sel = 0; m_sel = 0;
  endtask

  task automatic pulse(input bit slave, input bit ser);
    if (slave) begin if (ser) s_ser = 1; else s_ext = 1; end
    else       begin if (ser) m_ser = 1; else m_ext = 1; end
    @(negedge clk);
    m_ext = 0; m_ser = 0; s_ext = 0; s_ser = 0;
  endtask

  task automatic wait_edges(input int n);
    while (edges != n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] q;
    check("R1 m_ipl", 16'(m_ipl), 0);
    check("R1 s_ipl", 16'(s_ipl), 0);
    check("R1 snd_rst", 16'(snd_rst), 1);
    check("R1 slv_rst", 16'(slv_rst), 1);
    check("R1 io_rst", 16'(io_rst), 1);
    bus_rd(0, 7, q); check("R1 slot7 reads 0", q, 0);
  endtask

  task automatic t_position;
    bus_wr(0, 5, 3'd2);
    wait_edges(PL * LC);
    check("R12 before position line", 16'(m_ipl), 0);
    @(negedge clk);
    check("R12 position at line", 16'(m_ipl), 2);
    bus_wr(1, 5, 3'd3);
    check("R12 dropped at level 0", 16'(s_ipl), 0);
    bus_wr(1, 5, 3'd0);
    bus_wr(0, 13, 3'd0);
    check("R4 write ack position", 16'(m_ipl), 0);
    bus_wr(0, 5, 3'd0);
  endtask

  task automatic t_vblank;
    logic [15:0] q;
    bus_wr(0, 7, 3'd5);
    bus_wr(1, 7, 3'd6);
    check("R11 pending from edge 1", 16'(m_ipl), 5);
    bus_rd(0, 15, q);
    bus_rd(1, 15, q);
    check("R4 read ack vblank", 16'(m_ipl), 0);
    wait_edges(FRAME);
    check("R11 before frame wrap m", 16'(m_ipl), 0);
    @(negedge clk);
    check("R11 frame wrap m", 16'(m_ipl), 5);
    check("R11 frame wrap s", 16'(s_ipl), 6);
    bus_wr(0, 15, 3'd0);
    bus_wr(1, 15, 3'd0);
    bus_wr(0, 7, 3'd0);
    bus_wr(1, 7, 3'd0);
  endtask

  task automatic t_priority;
    logic [15:0] q;
    bus_wr(0, 4, 3'd2);
    bus_wr(0, 6, 3'd6);
    pulse(0, 0);
    check("R10 ext pending", 16'(m_ipl), 2);
    pulse(0, 1);
    check("R3 highest wins", 16'(m_ipl), 6);
    bus_wr(0, 14, 3'd0);
    check("R4 ack serial", 16'(m_ipl), 2);
    bus_rd(0, 12, q);
    check("R4 read ack ext", 16'(m_ipl), 0);
    bus_wr(0, 4, 3'd0);
    pulse(0, 0);
    check("R3 level 0 silent", 16'(m_ipl), 0);
    bus_wr(0, 12, 3'd0);
    bus_wr(0, 4, 3'd3);
    m_ext = 1; m_sel = 1; m_we = 0; m_idx = 5'd12;
    @(negedge clk);
    m_ext = 0; m_sel = 0;
    check("R4 event beats ack", 16'(m_ipl), 3);
    bus_wr(0, 12, 3'd0);
    pulse(1, 1);
    bus_wr(1, 6, 3'd7);
    check("R10 slave serial", 16'(s_ipl), 7);
    check("R10 master untouched", 16'(m_ipl), 0);
    bus_wr(1, 14, 3'd0);
    bus_wr(1, 6, 3'd0);
  endtask

  task automatic t_ipi;
    bus_wr(1, 3, 3'd4);
    bus_wr(0, 10, 3'd0);
    check("R5 slave receives", 16'(s_ipl), 4);
    check("R5 master unchanged", 16'(m_ipl), 0);
    bus_wr(1, 11, 3'd0);
    check("R5 slave ack", 16'(s_ipl), 0);
    bus_wr(0, 3, 3'd1);
    bus_wr(1, 10, 3'd0);
    check("R5 master receives", 16'(m_ipl), 1);
    bus_wr(0, 11, 3'd0);
  endtask

  task automatic t_regs;
    logic [15:0] q;
    bus_wr(0, 0, 3'd5);
    bus_rd(0, 0, q); check("R2 slot0 readback", q, 16'h0005);
    bus_wr(1, 20, 3'd3);
    bus_rd(1, 20, q); check("R2 slot20 readback", q, 16'h0003);
    bus_rd(0, 20, q); check("R2 banks separate", q, 16'h0000);
    bus_wr(0, 16, 3'd2);
    bus_rd(0, 16, q); check("R6 status all ones", q, 16'hFFFF);
  endtask

  task automatic t_resets;
    logic [15:0] q;
    bus_wr(1, 17, 3'd1);
    bus_wr(1, 18, 3'd1);
    check("R7 slave no snd effect", 16'(snd_rst), 1);
    check("R7 slave no sub effect", 16'(slv_rst), 1);
    bus_wr(0, 17, 3'd1);
    check("R7 snd released", 16'(snd_rst), 0);
    check("R8 sub still held", 16'(slv_rst), 1);
    bus_wr(0, 18, 3'd1);
    check("R8 slave released", 16'(slv_rst), 0);
    check("R8 io released", 16'(io_rst), 0);
    bus_wr(0, 17, 3'd0);
    check("R7 snd held", 16'(snd_rst), 1);
    bus_wr(0, 18, 3'd6);
    check("R8 slave held", 16'(slv_rst), 1);
    check("R8 io held", 16'(io_rst), 1);
    bus_rd(0, 18, q); check("R2 slot18 readback", q, 16'h0006);
  endtask

  task automatic t_kick;
    bus_wr(0, 19, 3'd0);
    check("R9 kick high", 16'(m_kick), 1);
    check("R9 other bank quiet", 16'(s_kick), 0);
    @(negedge clk);
    check("R9 kick one cycle", 16'(m_kick), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_position;
    t_vblank;
    t_priority;
    t_ipi;
    t_regs;
    t_resets;
    t_kick;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule